// File: doc/BRIEF.md
# Fixed-Prime 512-bit Modular Reducer

This block takes a 512-bit unsigned value and returns its residue modulo one of two built-in 256-bit primes. It is meant to sit after a wide multiplier in an elliptic-curve datapath: the 512-bit product goes in, and a fully reduced field element comes out. The default prime (select value 0) is the secp256k1 field prime 2^256 - 2^32 - 977. Select value 1 picks the NIST P-256 prime 2^256 - 2^224 + 2^192 + 2^96 - 1.

The block does not divide. It uses the sparse form of each prime instead. A first folding step brings the operand down to under 300 bits. Two further folds remove the bits above position 255. Two conditional subtractions then give a result strictly below the prime. Every step runs on every operation, so the latency is always five cycles, whatever the operand value and whichever prime is selected. A new operand can be accepted in the same cycle that the previous result is flagged, so the block accepts one operand every five cycles.

Top module: `mr_top`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and result_o is all zeros.
- R2: With prime_sel_i = 0 at the start cycle, the reported result equals the operand modulo 2^256 - 2^32 - 977.
- R3: With prime_sel_i = 1 at the start cycle, the reported result equals the operand modulo 2^256 - 2^224 + 2^192 + 2^96 - 1.
- R4: If start_i is accepted in cycle 0, done_o is high in cycle 5 and only in that cycle.
- R5: busy_o is high in cycles 1 to 4 after an accepted start and low in the cycle where done_o is high; busy_o and done_o are never high together.
- R6: A start_i raised while busy_o is high has no effect: the operand and select of the running operation are kept, and the timing and result are unchanged.
- R7: result_o changes only in a cycle where done_o is high, and it holds its value until the next completion.
- R8: A start_i raised in the cycle where done_o is high is accepted, so operations can follow one another every 5 cycles.
- R9: The reported result is always strictly less than the selected prime. This includes operands in [p, 2^256), operands equal to multiples of p, and the all-ones 512-bit operand.
- R10: The latency from start to done is 5 cycles for every operand value and for both primes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when busy_o is low |
| operand_i | input | 512 | Unsigned value to reduce, sampled when start is accepted |
| prime_sel_i | input | 1 | Prime select: 0 = secp256k1 field prime, 1 = P-256 prime |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | 256 | Reduced value; holds until the next completion |

## Verification
The hardest cases are the ones that exercise the carry paths after folding: a second fold that still has a set bit above position 255, and the second conditional subtraction. Random operands almost never produce these. The stimulus therefore uses hand-picked operands: values just at or above the prime, 2^256 - 1, exact multiples of the prime, squares of p - 1, and the all-ones 512-bit word, each run under both primes. Start strobes are also placed in the middle of a busy window and in the done cycle itself, and the cycle-accurate reference model shows whether they were ignored or accepted.

// File: rtl/mr_pkg.sv
package mr_pkg;
    parameter int OP_W       = 512;
    parameter int P_W        = 256;
    parameter int ACC_W      = 292;
    parameter int LATENCY    = 5;
    parameter int NUM_PRIMES = 2;
    parameter int SEL_W      = $clog2(NUM_PRIMES);
    parameter int STEP_W     = $clog2(LATENCY);
    parameter int HI_W       = ACC_W - P_W;

    localparam int PRIME_K256 = 0;
    localparam int PRIME_P256 = 1;

    // secp256k1: 2^256 - p = 2^32 + 977
    localparam int K_SHIFT = 32;
    localparam int K_LOW   = 977;

    // P-256: 2^256 - p = 2^224 - 2^192 - 2^96 + 1
    localparam int Q_SHIFT_A = 224;
    localparam int Q_SHIFT_B = 192;
    localparam int Q_SHIFT_C = 96;

    localparam logic [P_W-1:0] K256_P =
        256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;
    localparam logic [P_W-1:0] P256_P =
        256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF;

    function automatic logic [P_W-1:0] prime_value(input logic [SEL_W-1:0] s);
        return (s == SEL_W'(PRIME_P256)) ? P256_P : K256_P;
    endfunction

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [SEL_W-1:0]  sel;
        logic [OP_W-1:0]   data;
        logic [P_W-1:0]    result;
    } mr_state_t;
endpackage

// File: rtl/mr_coarse.sv
module mr_coarse
    import mr_pkg::*;
#(
    parameter int PRIME_ID = PRIME_K256
) (
    input  logic [OP_W-1:0]  x_i,
    output logic [ACC_W-1:0] y_o
);
    localparam int WORDS = OP_W / 32;

    logic [P_W-1:0] lo_w;
    logic [P_W-1:0] hi_w;
    assign lo_w = x_i[P_W-1:0];
    assign hi_w = x_i[OP_W-1:P_W];

    generate
        if (PRIME_ID == PRIME_K256) begin : g_k256
            // L + H * (2^32 + 977)
            assign y_o = ACC_W'(lo_w) + (ACC_W'(hi_w) << K_SHIFT)
                       + ACC_W'(hi_w) * ACC_W'(K_LOW);
        end else begin : g_p256
            logic [31:0] w [WORDS];
            for (genvar i = 0; i < WORDS; i++) begin : g_word
                assign w[i] = x_i[32*i +: 32];
            end
            logic [P_W-1:0] add1, add2, add3, add4, sub1, sub2, sub3, sub4;
            assign add1 = {w[15], w[14], w[13], w[12], w[11], 96'b0};
            assign add2 = {32'b0, w[15], w[14], w[13], w[12], 96'b0};
            assign add3 = {w[15], w[14], 96'b0, w[10], w[9], w[8]};
            assign add4 = {w[8], w[13], w[15], w[14], w[13], w[11], w[10], w[9]};
            assign sub1 = {w[10], w[8], 96'b0, w[13], w[12], w[11]};
            assign sub2 = {w[11], w[9], 64'b0, w[15], w[14], w[13], w[12]};
            assign sub3 = {w[12], 32'b0, w[10], w[9], w[8], w[15], w[14], w[13]};
            assign sub4 = {w[13], 32'b0, w[11], w[10], w[9], 32'b0, w[15], w[14]};
            // sum lies in (-4p, 5p); the 4p offset keeps it positive, below 2^260
            assign y_o = ACC_W'(lo_w)
                       + (ACC_W'(add1) << 1) + (ACC_W'(add2) << 1)
                       + ACC_W'(add3) + ACC_W'(add4)
                       + (ACC_W'(P256_P) << 2)
                       - ACC_W'(sub1) - ACC_W'(sub2) - ACC_W'(sub3) - ACC_W'(sub4);
        end
    endgenerate
endmodule

// File: rtl/mr_fold.sv
module mr_fold
    import mr_pkg::*;
#(
    parameter int PRIME_ID = PRIME_K256
) (
    input  logic [ACC_W-1:0] x_i,
    output logic [ACC_W-1:0] y_o
);
    logic [HI_W-1:0] hi;
    logic [P_W-1:0]  lo;
    assign hi = x_i[ACC_W-1:P_W];
    assign lo = x_i[P_W-1:0];

    generate
        if (PRIME_ID == PRIME_K256) begin : g_k256
            assign y_o = ACC_W'(lo) + (ACC_W'(hi) << K_SHIFT)
                       + ACC_W'(hi) * ACC_W'(K_LOW);
        end else begin : g_p256
            assign y_o = ACC_W'(lo) + (ACC_W'(hi) << Q_SHIFT_A)
                       - (ACC_W'(hi) << Q_SHIFT_B) - (ACC_W'(hi) << Q_SHIFT_C)
                       + ACC_W'(hi);
        end
    endgenerate
endmodule

// File: rtl/mr_csub.sv
module mr_csub
    import mr_pkg::*;
(
    input  logic [P_W-1:0] x_i,
    input  logic [P_W-1:0] p_i,
    output logic [P_W-1:0] y_o
);
    logic [P_W:0] diff;
    assign diff = {1'b0, x_i} - {1'b0, p_i};
    // borrow set means x < p: keep x
    assign y_o  = diff[P_W] ? x_i : diff[P_W-1:0];
endmodule

// File: rtl/mr_top.sv
module mr_top
    import mr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [OP_W-1:0]  operand_i,
    input  logic [SEL_W-1:0] prime_sel_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [P_W-1:0]   result_o
);
    localparam logic [STEP_W-1:0] STEP_FIRST = '0;
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(LATENCY - 2);

    mr_state_t st_d, st_q;

    logic [ACC_W-1:0] coarse_arr [NUM_PRIMES];
    logic [ACC_W-1:0] fold_arr   [NUM_PRIMES];
    logic [P_W-1:0]   cur_p;
    logic [P_W-1:0]   sub1_y, sub2_y;

    for (genvar g = 0; g < NUM_PRIMES; g++) begin : g_prime
        mr_coarse #(.PRIME_ID(g)) u_coarse (
            .x_i (st_q.data),
            .y_o (coarse_arr[g])
        );
        mr_fold #(.PRIME_ID(g)) u_fold (
            .x_i (st_q.data[ACC_W-1:0]),
            .y_o (fold_arr[g])
        );
    end

    assign cur_p = prime_value(st_q.sel);

    mr_csub u_sub1 (.x_i(st_q.data[P_W-1:0]), .p_i(cur_p), .y_o(sub1_y));
    mr_csub u_sub2 (.x_i(sub1_y),             .p_i(cur_p), .y_o(sub2_y));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.step = STEP_FIRST;
                st_d.sel  = prime_sel_i;
                st_d.data = operand_i;
            end
        end else begin
            st_d.step = st_q.step + STEP_W'(1);
            if (st_q.step == STEP_FIRST) begin
                st_d.data = OP_W'(coarse_arr[st_q.sel]);
            end else if (st_q.step < LAST_STEP) begin
                st_d.data = OP_W'(fold_arr[st_q.sel]);
            end else begin
                st_d.result = sub2_y;
                st_d.done   = 1'b1;
                st_d.busy   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign result_o = st_q.result;
endmodule

// File: rtl/mr_chk.sv
module mr_chk
    import mr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [SEL_W-1:0] sel,
    input logic [P_W-1:0]   result
);
    logic [3:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (start && !busy) begin
            cyc_q <= 4'd1;
        end else if (cyc_q != 4'd0 && cyc_q < 4'd7) begin
            cyc_q <= cyc_q + 4'd1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == 4'(LATENCY))); // R10
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R5
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_q >= 4'd1 && cyc_q <= 4'(LATENCY - 1))); // R5
    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sel)); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7
    AST_BELOW_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < prime_value(sel))); // R9
endmodule

bind mr_top mr_chk chk_i (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .start  (start_i),
    .busy   (busy_o),
    .done   (done_o),
    .sel    (st_q.sel),
    .result (result_o)
);

// File: tb/mr_top_tb.sv
module mr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] operand = '0;
    logic         sel = 1'b0;
    logic         busy, done;
    logic [255:0] result;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    logic [511:0] pk, pp;
    initial begin
        pk = (512'd1 << 256) - (512'd1 << 32) - 512'd977;
        pp = (512'd1 << 256) - (512'd1 << 224) + (512'd1 << 192) + (512'd1 << 96) - 512'd1;
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    mr_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .operand_i(operand),
        .prime_sel_i(sel), .busy_o(busy), .done_o(done), .result_o(result)
    );

    function automatic logic [255:0] ref_mod(input logic [511:0] x, input logic s);
        logic [511:0] m;
        m = s ? pp : pk;
        return 256'(x % m);
    endfunction

    // behavioural reference: accepted op finishes after four further edges
    logic         m_busy, m_done;
    int           m_left;
    logic [255:0] m_exp, m_res;
    logic         m_sel;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
            m_exp <= '0; m_res <= '0; m_sel <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1;
                    m_left <= 4;
                    m_exp  <= ref_mod(operand, sel);
                    m_sel  <= sel;
                end
            end else if (m_left == 1) begin
                m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_exp;
            end else begin
                m_left <= m_left - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(done === m_done, "R4 done", 256'(done), 256'(m_done));
            chk(busy === m_busy, "R5 busy", 256'(busy), 256'(m_busy));
            chk(result === m_res, m_sel ? "R3 R7 result" : "R2 R7 result", result, m_res);
        end
    end

    // called at a negedge; returns at the negedge where done is seen
    task automatic issue(input logic [511:0] x, input logic s, input bit poke);
        int n;
        logic [255:0] e;
        e = ref_mod(x, s);
        start = 1'b1; operand = x; sel = s;
        @(negedge clk);
        start = 1'b0; operand = ~x; sel = ~s;
        n = 1;
        while (!done && n < 12) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                start = 1'b1; operand = {16{32'hDEADBEEF}}; sel = ~s;
            end else begin
                start = 1'b0;
            end
        end
        chk(n == 5, "R10 latency", 256'(n), 256'd5);
        chk(result === e, s ? "R3 value" : "R2 value", result, e);
        chk(result < (s ? pp[255:0] : pk[255:0]), "R9 below prime", result,
            s ? pp[255:0] : pk[255:0]);
        if (poke) chk(result === e, "R6 mid-busy start ignored", result, e);
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", 256'(busy), 256'd0);
        chk(done === 1'b0, "R1 done", 256'(done), 256'd0);
        chk(result === '0, "R1 result", result, '0);
        cmp_en = 1'b1;

        for (int s = 0; s < 2; s++) begin
            logic [511:0] p;
            logic [511:0] corner [10];
            p = s ? pp : pk;
            corner[0] = '0;
            corner[1] = 512'd1;
            corner[2] = p - 1;
            corner[3] = p;
            corner[4] = p + 1;
            corner[5] = (512'd1 << 256) - 1;
            corner[6] = (p - 1) * (p - 1);
            corner[7] = p * p;
            corner[8] = '1;
            corner[9] = p * ((512'd1 << 255) + 512'd3);
            // back-to-back issues: each start lands in the previous done cycle (R8)
            for (int i = 0; i < 10; i++) issue(corner[i], s[0], 1'b0);
            idle(2);
        end

        // R6: start while busy, both primes
        issue(rnd512(), 1'b0, 1'b1);
        issue(rnd512(), 1'b1, 1'b1);

        // R7: result held over idle cycles
        begin
            logic [255:0] held;
            held = result;
            idle(1);
            held = result;
            idle(4);
            chk(result === held, "R7 hold", result, held);
            chk(done === 1'b0, "R4 no extra done", 256'(done), 256'd0);
        end

        // R8: explicit back-to-back with alternating primes
        issue(rnd512(), 1'b0, 1'b0);
        chk(busy === 1'b0, "R8 ready in done cycle", 256'(busy), 256'd0);
        issue(rnd512(), 1'b1, 1'b0);

        for (int i = 0; i < 60; i++) begin
            issue(rnd512(), i[0], 1'b0);
            if (i % 7 == 0) idle(i % 3);
        end

        idle(3);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end
endmodule